// File: doc/BRIEF.md
# Functional-register driven control point

This block is a bank of test-point cells that push selected internal nets toward a fixed value during pseudorandom self-test. No dedicated scan flop holds the activation value. Each cell takes its activation from a functional register bit that already feeds the net's logic cone. The block holds those driver registers, so the new path from register to control gate sits inside the same timing group as the functional path.

Each lane has a 2-bit type. The type selects an AND control gate, which pulls the net to 0, or an OR control gate, which pulls it to 1. It also selects whether the driver path takes the register's true or complemented output. The complemented output is chosen when the functional path from the same register is non-inverting, so the two paths always carry opposite inversion parity. A global test-point enable gates every lane. It only takes effect in test mode; in system mode every lane is transparent.

Top module: `tpc_point`

## Requirements
- R1: A lane whose type bit 0 is 1 (OR gate) drives `net_o` to 1 while the effective enable is high and its driver path value is 1.
- R2: A lane whose type bit 0 is 0 (AND gate) drives `net_o` to 0 while the effective enable is high and its driver path value is 1.
- R3: While the effective enable is high and a lane's driver path value is 0, that lane's `net_o` equals its `net_i`.
- R4: With `tp_en_i` = 0, `net_o` equals `net_i` on every lane, whatever the register contents.
- R5: With `test_mode_i` = 0 (system mode), `tp_en_i` is ignored and `net_o` equals `net_i` on every lane.
- R6: A lane whose type bit 1 is 1 takes its driver path value from the complemented register output, so it is active when its register holds 0. When type bit 1 is 0, the driver path value is the register bit itself.
- R7: Lane k's driver register loads `drv_d_i[k]` on each rising clock edge and shows it on `drv_q_o[k]`. `rst_ni` low clears it to 0 at once. `net_o` follows the new register value in the same cycle, with no further register.
- R8: Lane k's type is bits [2k+1:2k] of `TYPE_MAP`. The default 8'hE4 gives lane 0 type 00, lane 1 type 01, lane 2 type 10 and lane 3 type 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the driver registers |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tp_en_i | input | 1 | Global test-point enable |
| test_mode_i | input | 1 | 1 = self-test mode, 0 = system mode |
| drv_d_i | input | LANES | Functional next value of each driver register |
| drv_q_o | output | LANES | Driver register outputs, feeding the functional cone |
| net_i | input | LANES | Functional value of each controlled net |
| net_o | output | LANES | Controlled net values |

## Verification
A new register value and a forcing decision can land in the same cycle. The edge that loads a driver bit also switches its lane between forcing and passing, with no extra delay stage. The bench changes the register input, the net value and both enables together before each edge, covering every combination on all four lane types. Just after the edge, it checks both the register output and the forced or passed net against a model that uses the newly loaded bit.

// File: rtl/tpc_pkg.sv
package tpc_pkg;
  // bit 0: OR gate (force 1) vs AND gate (force 0); bit 1: complemented driver path
  typedef enum logic [1:0] {
    TPC_AND     = 2'b00,
    TPC_OR      = 2'b01,
    TPC_AND_INV = 2'b10,
    TPC_OR_INV  = 2'b11
  } tpc_type_e;

  function automatic bit tpc_is_or(tpc_type_e t);
    return t[0];
  endfunction

  function automatic bit tpc_is_inv(tpc_type_e t);
    return t[1];
  endfunction
endpackage

// File: rtl/tpc_drv_reg.sv
module tpc_drv_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o,
  output logic [W-1:0] qn_o
);
  logic [W-1:0] q_r;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_r <= '0;
    else         q_r <= d_i;
  end

  assign q_o  = q_r;
  assign qn_o = ~q_r;
endmodule

// File: rtl/tpc_cell.sv
module tpc_cell
  import tpc_pkg::*;
#(
  parameter tpc_type_e KIND = TPC_OR
) (
  input  logic net_i,
  input  logic drv_q_i,
  input  logic drv_qn_i,
  input  logic en_i,
  output logic net_o
);
  logic act;

  // driver path parity is set opposite to the functional path at insertion
  if (tpc_is_inv(KIND)) begin : g_inv
    assign act = drv_qn_i & en_i;
  end else begin : g_true
    assign act = drv_q_i & en_i;
  end

  if (tpc_is_or(KIND)) begin : g_or
    assign net_o = net_i | act;
  end else begin : g_and
    assign net_o = net_i & ~act;
  end
endmodule

// File: rtl/tpc_point.sv
module tpc_point
  import tpc_pkg::*;
#(
  parameter int unsigned          LANES    = 4,
  parameter logic [2*LANES-1:0]   TYPE_MAP = 8'hE4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tp_en_i,
  input  logic             test_mode_i,
  input  logic [LANES-1:0] drv_d_i,
  output logic [LANES-1:0] drv_q_o,
  input  logic [LANES-1:0] net_i,
  output logic [LANES-1:0] net_o
);
  logic [LANES-1:0] q, qn;
  logic             en_eff;

  // system mode overrides the global enable
  assign en_eff = tp_en_i & test_mode_i;

  tpc_drv_reg #(.W(LANES)) u_drv (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (drv_d_i),
    .q_o   (q),
    .qn_o  (qn)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam tpc_type_e KIND = tpc_type_e'(TYPE_MAP[2*k +: 2]);
    tpc_cell #(.KIND(KIND)) u_cell (
      .net_i   (net_i[k]),
      .drv_q_i (q[k]),
      .drv_qn_i(qn[k]),
      .en_i    (en_eff),
      .net_o   (net_o[k])
    );
  end

  assign drv_q_o = q;
endmodule

// File: rtl/tpc_point_chk.sv
module tpc_point_chk #(
  parameter int unsigned        LANES    = 4,
  parameter logic [2*LANES-1:0] TYPE_MAP = 8'hE4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tp_en_i,
  input logic             test_mode_i,
  input logic [LANES-1:0] drv_d_i,
  input logic [LANES-1:0] drv_q_o,
  input logic [LANES-1:0] net_i,
  input logic [LANES-1:0] net_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam bit IS_OR = TYPE_MAP[2*k];
    localparam bit INV   = TYPE_MAP[2*k+1]; // R6 polarity of driver path
    if (IS_OR) begin : g_or
      p_force_one_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tp_en_i && test_mode_i && (drv_q_o[k] ^ INV)) |-> net_o[k]);
    end else begin : g_and
      p_force_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tp_en_i && test_mode_i && (drv_q_o[k] ^ INV)) |-> !net_o[k]);
    end
    p_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tp_en_i && test_mode_i && !(drv_q_o[k] ^ INV)) |-> net_o[k] == net_i[k]);
  end

  p_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tp_en_i |-> net_o == net_i);

  p_sys_mode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_mode_i |-> net_o == net_i);

  p_capture_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> drv_q_o == $past(drv_d_i));
endmodule

bind tpc_point tpc_point_chk #(.LANES(LANES), .TYPE_MAP(TYPE_MAP)) u_chk (.*);

// File: tb/tpc_point_bench.sv
module tpc_point_bench;
  localparam int LANES = 4;
  // lane types per R8 default: 0=AND, 1=OR, 2=AND inverted, 3=OR inverted
  localparam bit [3:0] LANE_OR  = 4'b1010;
  localparam bit [3:0] LANE_INV = 4'b1100;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic             tp_en_i = 1'b0;
  logic             test_mode_i = 1'b0;
  logic [LANES-1:0] drv_d_i = '0;
  logic [LANES-1:0] drv_q_o;
  logic [LANES-1:0] net_i = '0;
  logic [LANES-1:0] net_o;

  int n_run = 0;
  int n_fail = 0;

  typedef struct packed {
    logic [3:0] d;
    logic [3:0] net;
    logic       en;
    logic       mode;
  } item_t;

  item_t sb_q[$];

  always #10 clk = ~clk;

  tpc_point u_tpc_point (
    .clk_i(clk), .rst_ni(rst_ni), .tp_en_i(tp_en_i), .test_mode_i(test_mode_i),
    .drv_d_i(drv_d_i), .drv_q_o(drv_q_o), .net_i(net_i), .net_o(net_o)
  );

  function automatic logic model_net(int k, logic q, logic n, logic en, logic mode);
    logic act;
    act = (LANE_INV[k] ? ~q : q) & en & mode;
    return LANE_OR[k] ? (n | act) : (n & ~act);
  endfunction

  function automatic string tag_of(int k, logic q, logic en, logic mode);
    logic act;
    if (!mode) return "R5";
    if (!en) return "R4";
    act = LANE_INV[k] ? ~q : q;
    if (!act) return "R3";
    if (LANE_INV[k]) return "R6";
    return LANE_OR[k] ? "R1" : "R2";
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] d, logic [3:0] n, logic en, logic mode);
    item_t it;
    @(negedge clk);
    drv_d_i = d; net_i = n; tp_en_i = en; test_mode_i = mode;
    it.d = d; it.net = n; it.en = en; it.mode = mode;
    sb_q.push_back(it);
  endtask

  // monitor: result of each driven item appears after the next rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        check("R7 capture", drv_q_o, it.d);
        for (int k = 0; k < LANES; k++)
          check(tag_of(k, it.d[k], it.en, it.mode), {3'b0, net_o[k]},
                {3'b0, model_net(k, it.d[k], it.net[k], it.en, it.mode)});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // reset state: registers 0, inverted lanes active under test enable
    test_mode_i = 1'b1; tp_en_i = 1'b1; net_i = 4'b0101; drv_d_i = 4'b1111;
    repeat (3) @(posedge clk);
    #5;
    check("R7 reset q", drv_q_o, 4'b0000);
    check("R6 reset net", net_o, 4'b1001);
    @(negedge clk);
    rst_ni = 1'b1;

    // every combination for all four lane types (R1..R6, R8)
    for (int m = 0; m < 2; m++)
      for (int e = 0; e < 2; e++)
        for (int d = 0; d < 16; d++)
          for (int n = 0; n < 16; n++)
            drive(4'(d), 4'(n), e[0], m[0]);

    // R5: system mode with enable held high, registers all 1 then all 0
    drive(4'hF, 4'h6, 1'b1, 1'b0);
    drive(4'h0, 4'h9, 1'b1, 1'b0);
    repeat (2) @(posedge clk);

    // R7: asynchronous clear mid-cycle
    @(negedge clk);
    drv_d_i = 4'hA; test_mode_i = 1'b1; tp_en_i = 1'b1; net_i = 4'h0;
    @(posedge clk);
    #5;
    check("R7 load before clear", drv_q_o, 4'hA);
    check("R1 after load", net_o, 4'b0010);
    rst_ni = 1'b0;
    #1;
    check("R7 async clear", drv_q_o, 4'h0);
    check("R6 after clear", net_o, 4'b1000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule